// File: doc/BRIEF.md
# Byte-stream program bootstrap loader

This block fills a 24-bit-wide program memory from a byte-wide source when the chip leaves reset. On the first clock edge after the active-low reset is released it copies four mode pins into a mode register. That mode decides whether anything is loaded at all. In a loading mode, bytes arrive over a valid/ready input. The stream first carries a word count, then a start address, then the program words. Every field is three bytes wide and is packed lowest byte first.

Each finished program word is written to memory through a registered address/data/write-enable port, at consecutive addresses starting from the start address. When the last word has been written, the block raises a one-cycle done pulse and presents the start address as the jump target for the processor. In host-port modes, a host flag ends the download early and still hands over the start address.

Top module: `boot_loader`

## Requirements
- R1: On the first rising clock edge after rst_ni goes high, mode_o takes the value of mode_pins_i; mode_o then keeps that value until the next reset, whatever mode_pins_i does.
- R2: Mode values 0 and 8 (low three mode bits zero) are normal modes. In a normal mode, byte_ready_o never goes high and mem_we_o never goes high. done_o pulses in the second cycle after reset release with jump_addr_o equal to 0.
- R3: In loading modes the first three accepted bytes form the word count and the next three form the start address. Each field is packed least significant byte first, so byte k of a field fills bits 8k+7..8k.
- R4: Each following group of three bytes, least significant byte first, becomes one program word. It is written with mem_we_o high for exactly one cycle. Successive words go to the start address, then the start address plus 1, and so on, modulo 2^24.
- R5: byte_ready_o is low in every cycle in which mem_we_o is high.
- R6: After the requested number of words has been written, done_o is high for exactly one cycle with jump_addr_o equal to the start address. byte_ready_o stays low from then until the next reset.
- R7: A word count of zero ends the load right after the six header bytes, with no memory write and with jump_addr_o equal to the start address.
- R8: In host-port modes (mode bit 2 set: values 4 to 7 and 12 to 15), a high host_flag_i during loading drops byte_ready_o in the same cycle. done_o follows in the next cycle, no further word is written, and jump_addr_o equals the start address if it was complete (0 otherwise).
- R9: In the other loading modes (1 to 3 and 9 to 11), host_flag_i has no effect, and the load runs to its full word count.
- R10: busy_o is high during reset and from reset release until done_o rises. It is low in the done cycle and afterwards, and byte_ready_o is only ever high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_pins_i | input | 4 | Mode select pins, sampled after reset |
| host_flag_i | input | 1 | Early stop request (host-port modes only) |
| byte_i | input | 8 | Incoming byte |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_ready_o | output | 1 | Loader accepts a byte this cycle |
| mem_addr_o | output | 24 | Program memory write address |
| mem_data_o | output | 24 | Program memory write data |
| mem_we_o | output | 1 | Program memory write enable |
| mode_o | output | 4 | Latched mode register |
| busy_o | output | 1 | Loader has not finished |
| done_o | output | 1 | One-cycle completion pulse |
| jump_addr_o | output | 24 | Address where execution starts |

## Verification
The checker watches, on every cycle, the handshake rules and the shape of the outputs:
- byte_ready_o is never high while a write is in progress or after busy_o falls;
- done_o lasts one cycle and coincides with the fall of busy_o;
- every write lands one address above the previous one;
- a normal mode never writes.

The bench scenarios show what no single-cycle property can:
- that header bytes are packed least significant byte first;
- that the written data and the jump address match the stream that was sent;
- that a zero count or a host stop ends the load with the right number of writes;
- that the host flag is ignored outside host modes.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
package boot_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [2:0] {
    S_LATCH, S_COUNT, S_ADDR, S_DATA, S_WRITE, S_DONE, S_IDLE
  } boot_state_e;

  // 0 and 8: no load
  function automatic logic mode_is_normal(input logic [MODE_W-1:0] m);
    return m[2:0] == 3'b000;
  endfunction

  function automatic logic mode_is_host(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/boot_mode_reg.sv
`timescale 1ns/1ps
module boot_mode_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] mode_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mode_o[g] <= 1'b0;
      else if (load_i) mode_o[g] <= pins_i[g];
    end
  end
endmodule

// File: rtl/boot_byte_packer.sv
`timescale 1ns/1ps
module boot_byte_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0]             idx_q;
  logic [LANES-1:0][BYTE_W-1:0] lane_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lane_q[g] <= '0;
      else if (take_i && idx_q == IDX_W'(g))  lane_q[g] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      full_o <= 1'b0;
    end else begin
      full_o <= take_i && idx_q == LAST;
      if (take_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign word_o = lane_q;
endmodule

// File: rtl/boot_ctrl.sv
`timescale 1ns/1ps
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] pins_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              host_flag_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              latch_o,
  output logic              ready_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              mem_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] jump_o
);
  boot_state_e       state_q;
  logic [WORD_W-1:0] cnt_q, addr_q;
  logic              loading, stop;

  assign loading = state_q inside {S_COUNT, S_ADDR, S_DATA};
  assign stop    = mode_is_host(mode_i) && host_flag_i;
  assign ready_o = loading && !full_i && !stop;
  assign latch_o = state_q == S_LATCH;
  assign busy_o  = !(state_q inside {S_DONE, S_IDLE});
  assign done_o  = state_q == S_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_LATCH;
      cnt_q      <= '0;
      addr_q     <= '0;
      jump_o     <= '0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      mem_we_o   <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      unique case (state_q)
        S_LATCH: state_q <= mode_is_normal(pins_i) ? S_DONE : S_COUNT;
        S_COUNT, S_ADDR, S_DATA, S_WRITE: begin
          if (stop) begin
            state_q <= S_DONE;
          end else if (state_q == S_WRITE) begin
            state_q <= (cnt_q == '0) ? S_DONE : S_DATA;
          end else if (full_i) begin
            if (state_q == S_COUNT) begin
              cnt_q   <= word_i;
              state_q <= S_ADDR;
            end else if (state_q == S_ADDR) begin
              addr_q  <= word_i;
              jump_o  <= word_i;
              state_q <= (cnt_q == '0) ? S_DONE : S_DATA;
            end else begin
              mem_we_o   <= 1'b1;
              mem_addr_o <= addr_q;
              mem_data_o <= word_i;
              addr_q     <= addr_q + 1'b1;
              cnt_q      <= cnt_q - 1'b1;
              state_q    <= S_WRITE;
            end
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_loader.sv
`timescale 1ns/1ps
module boot_loader
  import boot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_pins_i,
  input  logic              host_flag_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              mem_we_o,
  output logic [3:0]        mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] jump_addr_o
);
  logic              latch, full, take;
  logic [WORD_W-1:0] word;

  assign take = byte_valid_i && byte_ready_o;

  boot_mode_reg #(.W(MODE_W)) i_mode (
    .clk_i, .rst_ni, .load_i(latch), .pins_i(mode_pins_i), .mode_o
  );

  boot_byte_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_pack (
    .clk_i, .rst_ni, .take_i(take), .byte_i, .word_o(word), .full_o(full)
  );

  boot_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk_i, .rst_ni, .pins_i(mode_pins_i), .mode_i(mode_o),
    .host_flag_i, .full_i(full), .word_i(word), .latch_o(latch),
    .ready_o(byte_ready_o), .mem_addr_o, .mem_data_o, .mem_we_o,
    .busy_o, .done_o, .jump_o(jump_addr_o)
  );
endmodule

// File: rtl/boot_loader_chk.sv
`timescale 1ns/1ps
module boot_loader_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_ready_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [3:0]        mode_o,
  input logic              busy_o,
  input logic              done_o
);
  logic [WORD_W-1:0] last_q;
  logic              seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (mem_we_o) begin
      last_q <= mem_addr_o;
      seen_q <= 1'b1;
    end
  end

  p_no_ready_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !byte_ready_o);
  p_consecutive_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && seen_q) |-> mem_addr_o == last_q + 1'b1);
  p_write_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_normal_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[2:0] == 3'b000) |-> !mem_we_o);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  p_done_not_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_busy_fall_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_ready_needs_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o);
  p_mode_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(mode_o));
endmodule

bind boot_loader boot_loader_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_boot_loader.sv
`timescale 1ns/1ps
module test_boot_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = '0;
  logic        flag = 1'b0;
  logic [7:0]  bdata = '0;
  logic        bvalid = 1'b0;
  logic        ready, we, busy, done;
  logic [23:0] maddr, mdata, jump;
  logic [3:0]  mode;

  int checks = 0, errors = 0, cycles = 0;
  int done_cnt = 0, overlap = 0, ready_seen = 0;
  logic [23:0] done_jump;
  logic        done_busy;
  logic [23:0] wr_a[$], wr_d[$];

  boot_loader i_boot_loader (
    .clk_i(clk), .rst_ni(rst_n), .mode_pins_i(pins), .host_flag_i(flag),
    .byte_i(bdata), .byte_valid_i(bvalid), .byte_ready_o(ready),
    .mem_addr_o(maddr), .mem_data_o(mdata), .mem_we_o(we), .mode_o(mode),
    .busy_o(busy), .done_o(done), .jump_addr_o(jump)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (we) begin wr_a.push_back(maddr); wr_d.push_back(mdata); end
      if (we && ready) overlap++;
      if (ready) ready_seen++;
      if (done) begin done_cnt++; done_jump = jump; done_busy = busy; end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: run hung, actual=%0d expected=<150000 cycles", cycles);
    summary();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] word_of(input int salt, input int i);
    return 24'((salt * 40503 + i * 9973) ^ (i << 13) ^ salt);
  endfunction

  task automatic do_reset(input logic [3:0] m);
    rst_n = 1'b0; pins = m; flag = 1'b0; bvalid = 1'b0;
    repeat (2) @(negedge clk);
    check(!ready && !we && !done && busy, "R10", "reset outputs rdy/we/done/busy",
          {ready, we, done, busy}, 4'b0001);
    wr_a.delete(); wr_d.delete();
    done_cnt = 0; ready_seen = 0; overlap = 0;
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(posedge clk);
    #1;
    bvalid = 1'b1; bdata = b;
    @(negedge clk);
    while (!ready) @(negedge clk);
    @(posedge clk); #1;
    bvalid = 1'b0;
  endtask

  task automatic send_field(input logic [23:0] v, input bit rnd);
    for (int k = 0; k < 3; k++)
      send_byte(v[8*k +: 8], rnd ? int'($urandom_range(0, 2)) : 0);
  endtask

  task automatic wait_done();
    for (int n = 0; n < 400 && done_cnt == 0; n++) @(negedge clk);
  endtask

  // full load and comparison against expected writes
  task automatic run_load(input logic [3:0] m, input int cnt, input logic [23:0] a,
                          input int salt, input bit rnd, input string req);
    do_reset(m);
    check(mode == m, "R1", "mode latched", mode, m);
    send_field(24'(cnt), rnd);
    send_field(a, rnd);
    for (int i = 0; i < cnt; i++) send_field(word_of(salt, i), rnd);
    wait_done();
    repeat (2) @(negedge clk);
    check(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
    check(done_jump == a, "R6", "jump address", done_jump, a);
    check(!done_busy, "R10", "busy low at done", done_busy, 0);
    check(wr_a.size() == cnt, req, "write count", wr_a.size(), cnt);
    for (int i = 0; i < cnt && i < wr_a.size(); i++) begin
      if (wr_a[i] != 24'(a + i) || wr_d[i] != word_of(salt, i)) begin
        check(1'b0, "R4", "write addr", wr_a[i], 24'(a + i));
        check(1'b0, "R4", "write data", wr_d[i], word_of(salt, i));
      end
    end
    check(wr_a.size() == cnt, "R4", "all writes matched", wr_a.size(), cnt);
    check(overlap == 0, "R5", "ready during write", overlap, 0);
    check(!ready && !busy, "R6", "ready/busy after done", {ready, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R1 and R2: normal mode 8, pins change after latch
    do_reset(4'd8);
    pins = 4'd3;
    @(negedge clk);
    check(mode == 4'd8, "R1", "mode held after pin change", mode, 8);
    check(done && jump == 24'd0, "R2", "done in 2nd cycle, jump 0", {done, jump}, {1'b1, 24'd0});
    repeat (3) @(negedge clk);
    check(ready_seen == 0 && wr_a.size() == 0, "R2", "no ready/write in normal mode",
          ready_seen + wr_a.size(), 0);
    check(done_cnt == 1, "R2", "single done", done_cnt, 1);

    do_reset(4'd0);
    repeat (4) @(negedge clk);
    check(done_cnt == 1 && ready_seen == 0, "R2", "mode 0 normal", done_cnt, 1);

    // R3: count with nonzero middle byte (0x000101 = 257)
    run_load(4'd2, 257, 24'h12A0F3, 7, 1'b0, "R3");
    // R4: address wrap
    run_load(4'd1, 2, 24'hFFFFFF, 11, 1'b0, "R4");
    // R7: zero count in host mode
    run_load(4'd12, 0, 24'h00ABCD, 3, 1'b0, "R7");

    // R8: host stop after two of five words
    do_reset(4'd5);
    send_field(24'd5, 1'b0);
    send_field(24'h001000, 1'b0);
    send_field(word_of(1, 0), 1'b0);
    send_field(word_of(1, 1), 1'b0);
    repeat (3) @(posedge clk);
    #1 flag = 1'b1; bvalid = 1'b1; bdata = 8'h55;
    #1;
    check(!ready, "R8", "ready drops with flag", ready, 0);
    wait_done();
    repeat (4) @(negedge clk);
    check(done_cnt == 1 && done_jump == 24'h001000, "R8", "stop done/jump", done_jump, 24'h001000);
    check(wr_a.size() == 2, "R8", "writes before stop", wr_a.size(), 2);
    check(!ready, "R8", "ready low after stop", ready, 0);
    bvalid = 1'b0; flag = 1'b0;

    // R8: stop before the address is complete -> jump 0
    do_reset(4'd7);
    send_field(24'd4, 1'b0);
    send_byte(8'h44, 0);
    #1 flag = 1'b1;
    wait_done();
    @(negedge clk);
    check(done_cnt == 1 && done_jump == 24'd0, "R8", "early stop jump 0", done_jump, 0);
    flag = 1'b0;

    // R9: flag ignored in mode 9
    do_reset(4'd9);
    flag = 1'b1;
    send_field(24'd3, 1'b0);
    send_field(24'h000400, 1'b0);
    for (int i = 0; i < 3; i++) send_field(word_of(5, i), 1'b0);
    wait_done();
    repeat (2) @(negedge clk);
    check(wr_a.size() == 3 && done_jump == 24'h000400, "R9", "flag ignored, full load",
          wr_a.size(), 3);
    flag = 1'b0;

    // random loads across loading modes
    for (int t = 0; t < 12; t++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      if (m[2:0] == 3'b000) m = 4'd1;
      run_load(m, int'($urandom_range(1, 6)), 24'($urandom()), t + 20, 1'b1, "R4");
    end

    summary();
  end
endmodule